// File: doc/BRIEF.md
# Windowed 2D Block Register File Engine

A bank of 512-bit registers that can be used in two ways. A host port reads and writes a whole register as one flat vector. A block sequencer treats the same storage as a grid of signed 8-bit elements. Each register is 8 rows by 8 columns, and the registers are stacked in row-major order to form one tall grid. Rows are addressed globally as `register*8 + row`, so a window may start on any row and any column and may run on into the next register.

One command names rectangular windows and their sizes. The sequencer then steps through every element without further help. There are two operations. A block move copies an M x N window to another position. A matrix-multiply reduction multiplies an M x K window by a K x N window. It forms each result as a dot product and stores it as a signed 32-bit word.

Commands use a valid/ready handshake. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low until that command has finished. While it is low, the requester must hold its command steady and wait. A one-cycle `done` pulse ends every command, and `err` marks a command that was refused.

Top module: `blkrf_engine`

## Requirements
- R1: Registers clear to zero at reset. A host write stores all 512 bits of `host_wdata` into register `host_waddr` at the clock edge. `host_rdata` always shows register `host_raddr` combinationally.
- R2: Element (row r, column c) of a register sits at bits `[(r*8+c)*8 +: 8]`. A window row at global row g lives in register g/8, row g%8. A window may span two or more consecutive registers.
- R3: A move (`cmd_op`=0) copies the M x N window that starts at (`cmd_a_row`, `cmd_a_col`) to the window that starts at (`cmd_d_row`, `cmd_d_col`). Every other element keeps its value.
- R4: When the source and destination windows of a move overlap, the result equals a copy taken from a snapshot of the source made before any write.
- R5: A matrix multiply (`cmd_op`=1) computes D(i,j) = sum over t<K of A(i,t)*B(t,j) as signed 32-bit values. A starts at (`cmd_a_row`, `cmd_a_col`) and B starts at (`cmd_b_row`, `cmd_b_col`). Word w = i*N+j is written to register `cmd_d_row/8 + w/16`, bits `[(w%16)*32 +: 32]`. All other words are unchanged. `cmd_d_col` and `cmd_d_row[2:0]` are ignored.
- R6: `cmd_ready` is high only when the engine is idle. A command is accepted when `cmd_valid` and `cmd_ready` are both high at an edge. `cmd_ready` is low from the following cycle until `done` has pulsed.
- R7: `done` is high for exactly one cycle per accepted command. It follows the last register write. `err` is low for a legal command.
- R8: A command is refused under any of these conditions: M or N (or K for a multiply) is 0 or greater than 8; a window's columns run past column 7; a window's rows run past the last global row; the multiply result words run past the last register. A refused command pulses `done` with `err`=1 and changes no register.
- R9: A host write presented while `cmd_ready` is low is ignored.
- R10: Latency is counted from the accepting edge. A refused command raises `done` right after that edge. A move raises `done` after 2*M*N further edges. A multiply produces one output word per cycle and raises `done` after M*N further edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_we | input | 1 | Flat register write strobe |
| host_waddr | input | 3 | Register written by the host |
| host_wdata | input | 512 | Flat write data |
| host_raddr | input | 3 | Register shown on host_rdata |
| host_rdata | output | 512 | Flat read data |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 1 | 0 move, 1 matrix multiply |
| cmd_a_row | input | 6 | Global start row of source / A window |
| cmd_a_col | input | 3 | Start column of source / A window |
| cmd_b_row | input | 6 | Global start row of B window |
| cmd_b_col | input | 3 | Start column of B window |
| cmd_d_row | input | 6 | Global start row of destination (register in bits 5:3 for multiply) |
| cmd_d_col | input | 3 | Start column of move destination |
| cmd_m | input | 4 | Rows of the result |
| cmd_k | input | 4 | Inner dimension of a multiply |
| cmd_n | input | 4 | Columns of the result |
| done | output | 1 | Completion pulse |
| err | output | 1 | Command refused, valid with done |

## Verification
The bench aims at overlapping moves in both directions. A design that copies in place would smear already-written bytes into later elements. Windows that straddle a register boundary would land in the wrong register if the global row were split badly. The bench also covers the edges of the bounds check: a window ending exactly on column 7 or on the last row, and a multiply result that fills the file exactly. An off-by-one there would either refuse legal commands or write past the file. Multiply operands are pseudo-random, so signed products appear often. Zero-extension or truncation to 8 bits would show in the result words. Host writes issued during a busy command, and exact `done` latencies, expose a missing busy gate and extra or missing sequencer cycles.

// File: rtl/blkrf_pkg.sv
package blkrf_pkg;
  localparam int REG_BITS  = 512;
  localparam int GRID      = 8;
  localparam int ELEM_BITS = 8;
  localparam int ACC_BITS  = 32;
  localparam int WPR       = REG_BITS / ACC_BITS;
  localparam int DIMW      = $clog2(GRID) + 1;

  localparam logic OP_MOVE   = 1'b0;
  localparam logic OP_MATMUL = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GATHER, ST_SCATTER, ST_MAC, ST_FIN
  } seq_state_e;
endpackage

// File: rtl/blkrf_cmd_check.sv
module blkrf_cmd_check
  import blkrf_pkg::*;
#(
  parameter int NREGS = 8,
  parameter int GRW   = $clog2(NREGS) + 3
) (
  input  logic            op,
  input  logic [GRW-1:0]  a_row,
  input  logic [2:0]      a_col,
  input  logic [GRW-1:0]  b_row,
  input  logic [2:0]      b_col,
  input  logic [GRW-1:0]  d_row,
  input  logic [2:0]      d_col,
  input  logic [DIMW-1:0] m,
  input  logic [DIMW-1:0] k,
  input  logic [DIMW-1:0] n,
  output logic            bad
);
  localparam int TOT = NREGS * GRID;

  always_comb begin
    int mm, kk, nn;
    mm  = int'(m);
    kk  = int'(k);
    nn  = int'(n);
    bad = 1'b0;
    if (mm < 1 || mm > GRID || nn < 1 || nn > GRID) bad = 1'b1;
    if (op == OP_MOVE) begin
      if (int'(a_col) + nn > GRID || int'(a_row) + mm > TOT) bad = 1'b1;
      if (int'(d_col) + nn > GRID || int'(d_row) + mm > TOT) bad = 1'b1;
    end else begin
      if (kk < 1 || kk > GRID) bad = 1'b1;
      if (int'(a_col) + kk > GRID || int'(a_row) + mm > TOT) bad = 1'b1;
      if (int'(b_col) + nn > GRID || int'(b_row) + kk > TOT) bad = 1'b1;
      if ((int'(d_row) / GRID) * WPR + mm * nn > NREGS * WPR) bad = 1'b1;
    end
  end
endmodule

// File: rtl/blkrf_dot.sv
module blkrf_dot
  import blkrf_pkg::*;
#(
  parameter int LANES = GRID,
  parameter int EW    = ELEM_BITS,
  parameter int AW    = ACC_BITS,
  parameter int KW    = $clog2(LANES) + 1
) (
  input  logic [EW-1:0] a_i [LANES],
  input  logic [EW-1:0] b_i [LANES],
  input  logic [KW-1:0] k_i,
  output logic [AW-1:0] sum_o
);
  logic [AW-1:0] term [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [2*EW-1:0] p;
    assign p       = $signed(a_i[l]) * $signed(b_i[l]);
    assign term[l] = (l < int'(k_i)) ? {{(AW-2*EW){p[2*EW-1]}}, p} : '0;
  end

  always_comb begin
    sum_o = '0;
    for (int l = 0; l < LANES; l++) sum_o = sum_o + term[l];
  end
endmodule

// File: rtl/blkrf_engine.sv
module blkrf_engine
  import blkrf_pkg::*;
#(
  parameter int NREGS = 8,
  localparam int RW   = $clog2(NREGS),
  localparam int GRW  = RW + 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_we,
  input  logic [RW-1:0]       host_waddr,
  input  logic [REG_BITS-1:0] host_wdata,
  input  logic [RW-1:0]       host_raddr,
  output logic [REG_BITS-1:0] host_rdata,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_op,
  input  logic [GRW-1:0]      cmd_a_row,
  input  logic [2:0]          cmd_a_col,
  input  logic [GRW-1:0]      cmd_b_row,
  input  logic [2:0]          cmd_b_col,
  input  logic [GRW-1:0]      cmd_d_row,
  input  logic [2:0]          cmd_d_col,
  input  logic [DIMW-1:0]     cmd_m,
  input  logic [DIMW-1:0]     cmd_k,
  input  logic [DIMW-1:0]     cmd_n,
  output logic                done,
  output logic                err
);
  localparam int TOT = NREGS * GRID;
  localparam int IW  = $clog2(GRID);

  logic [REG_BITS-1:0]  mem [NREGS];
  logic [ELEM_BITS-1:0] stage_q [GRID*GRID];
  seq_state_e           st;
  logic                 op_q, err_q;
  logic [GRW-1:0]       a_row_q, b_row_q, d_row_q;
  logic [2:0]           a_col_q, b_col_q, d_col_q;
  logic [DIMW-1:0]      m_q, k_q, n_q;
  logic [IW-1:0]        i_q, j_q;
  logic                 cmd_bad, last_j, last_i, accept;

  // element fetch from the stacked grid; out-of-range reads give zero
  function automatic logic [ELEM_BITS-1:0] pick(input int g, input int c);
    if (g < TOT && c < GRID)
      return mem[RW'(g / GRID)][((g % GRID) * GRID + c) * ELEM_BITS +: ELEM_BITS];
    return '0;
  endfunction

  blkrf_cmd_check #(.NREGS(NREGS), .GRW(GRW)) u_check (
    .op(cmd_op), .a_row(cmd_a_row), .a_col(cmd_a_col), .b_row(cmd_b_row),
    .b_col(cmd_b_col), .d_row(cmd_d_row), .d_col(cmd_d_col),
    .m(cmd_m), .k(cmd_k), .n(cmd_n), .bad(cmd_bad)
  );

  assign cmd_ready  = (st == ST_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign done       = (st == ST_FIN);
  assign err        = (st == ST_FIN) && err_q;
  assign host_rdata = mem[host_raddr];
  assign last_j     = ({1'b0, j_q} == n_q - 1'b1);
  assign last_i     = ({1'b0, i_q} == m_q - 1'b1);

  // operand lanes for the dot product, source element for the move
  logic [ELEM_BITS-1:0] a_lane [GRID];
  logic [ELEM_BITS-1:0] b_lane [GRID];
  logic [ELEM_BITS-1:0] src_byte;
  logic [ACC_BITS-1:0]  dot_sum;
  int                   sc_reg, sc_off, mac_reg, mac_off;

  always_comb begin
    int w, g;
    for (int t = 0; t < GRID; t++) begin
      a_lane[t] = pick(int'(a_row_q) + int'(i_q), int'(a_col_q) + t);
      b_lane[t] = pick(int'(b_row_q) + t, int'(b_col_q) + int'(j_q));
    end
    src_byte = pick(int'(a_row_q) + int'(i_q), int'(a_col_q) + int'(j_q));
    g        = int'(d_row_q) + int'(i_q);
    sc_reg   = g / GRID;
    sc_off   = ((g % GRID) * GRID + int'(d_col_q) + int'(j_q)) * ELEM_BITS;
    w        = int'(i_q) * int'(n_q) + int'(j_q);
    mac_reg  = int'(d_row_q) / GRID + w / WPR;
    mac_off  = (w % WPR) * ACC_BITS;
  end

  blkrf_dot #(.LANES(GRID)) u_dot (
    .a_i(a_lane), .b_i(b_lane), .k_i(k_q), .sum_o(dot_sum)
  );

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      op_q    <= OP_MOVE;
      err_q   <= 1'b0;
      a_row_q <= '0; b_row_q <= '0; d_row_q <= '0;
      a_col_q <= '0; b_col_q <= '0; d_col_q <= '0;
      m_q     <= '0; k_q <= '0; n_q <= '0;
      i_q     <= '0; j_q <= '0;
    end else begin
      if (st == ST_GATHER || st == ST_SCATTER || st == ST_MAC) begin
        if (last_j) begin
          j_q <= '0;
          i_q <= last_i ? '0 : i_q + 1'b1;
        end else begin
          j_q <= j_q + 1'b1;
        end
      end
      case (st)
        ST_IDLE: if (accept) begin
          op_q    <= cmd_op;
          err_q   <= cmd_bad;
          a_row_q <= cmd_a_row; a_col_q <= cmd_a_col;
          b_row_q <= cmd_b_row; b_col_q <= cmd_b_col;
          d_row_q <= cmd_d_row; d_col_q <= cmd_d_col;
          m_q     <= cmd_m; k_q <= cmd_k; n_q <= cmd_n;
          i_q     <= '0; j_q <= '0;
          if (cmd_bad)                  st <= ST_FIN;
          else if (cmd_op == OP_MATMUL) st <= ST_MAC;
          else                          st <= ST_GATHER;
        end
        ST_GATHER:  if (last_i && last_j) st <= ST_SCATTER;
        ST_SCATTER: if (last_i && last_j) st <= ST_FIN;
        ST_MAC:     if (last_i && last_j) st <= ST_FIN;
        default:    st <= ST_IDLE;
      endcase
    end
  end

  // snapshot of the move source, so overlap cannot corrupt it
  always_ff @(posedge clk) begin
    if (st == ST_GATHER) stage_q[{i_q, j_q}] <= src_byte;
  end

  // storage: host writes only while idle, engine writes while busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++) mem[r] <= '0;
    end else begin
      if (st == ST_IDLE && host_we) mem[host_waddr] <= host_wdata;
      if (st == ST_SCATTER)
        mem[RW'(sc_reg)][sc_off +: ELEM_BITS] <= stage_q[{i_q, j_q}];
      if (st == ST_MAC)
        mem[RW'(mac_reg)][mac_off +: ACC_BITS] <= dot_sum;
    end
  end

  // R6: once a command is taken the engine reports busy
  p_busy_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready);

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: a clean completion follows a writing phase
  p_done_after_work_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !err) |-> $past(st == ST_SCATTER || st == ST_MAC));

  // R8: a refused command finishes at once, flagged
  p_bad_cmd_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_bad) |=> (done && err));
endmodule

// File: tb/blkrf_engine_tb_top.sv
`timescale 1ns/1ps
module blkrf_engine_tb_top;
  localparam int NREGS = 8;
  localparam int NVEC  = 15;

  typedef struct packed {
    logic       op;
    logic [5:0] ar; logic [2:0] ac;
    logic [5:0] br; logic [2:0] bc;
    logic [5:0] dr; logic [2:0] dc;
    logic [3:0] m;  logic [3:0] k;  logic [3:0] n;
    logic       bad;
  } vec_t;

  // op ar ac br bc dr dc m k n bad
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 6'd3,  3'd2, 6'd0,  3'd0, 6'd20, 3'd5, 4'd2, 4'd1, 4'd3, 1'b0},
    '{1'b0, 6'd0,  3'd0, 6'd0,  3'd0, 6'd8,  3'd0, 4'd8, 4'd1, 4'd8, 1'b0},
    '{1'b0, 6'd6,  3'd1, 6'd0,  3'd0, 6'd13, 3'd3, 4'd4, 4'd1, 4'd5, 1'b0},
    '{1'b0, 6'd10, 3'd0, 6'd0,  3'd0, 6'd12, 3'd2, 4'd4, 4'd1, 4'd6, 1'b0},
    '{1'b0, 6'd12, 3'd2, 6'd0,  3'd0, 6'd10, 3'd0, 4'd4, 4'd1, 4'd6, 1'b0},
    '{1'b1, 6'd16, 3'd1, 6'd24, 3'd0, 6'd40, 3'd0, 4'd4, 4'd7, 4'd4, 1'b0},
    '{1'b1, 6'd0,  3'd0, 6'd8,  3'd0, 6'd32, 3'd0, 4'd8, 4'd8, 4'd8, 1'b0},
    '{1'b1, 6'd63, 3'd7, 6'd0,  3'd0, 6'd56, 3'd0, 4'd1, 4'd1, 4'd1, 1'b0},
    '{1'b1, 6'd5,  3'd3, 6'd30, 3'd4, 6'd48, 3'd0, 4'd3, 4'd5, 4'd4, 1'b0},
    '{1'b0, 6'd0,  3'd6, 6'd0,  3'd0, 6'd0,  3'd0, 4'd1, 4'd1, 4'd3, 1'b1},
    '{1'b0, 6'd0,  3'd0, 6'd0,  3'd0, 6'd8,  3'd0, 4'd0, 4'd1, 4'd2, 1'b1},
    '{1'b1, 6'd0,  3'd0, 6'd8,  3'd0, 6'd56, 3'd0, 4'd4, 4'd2, 4'd5, 1'b1},
    '{1'b0, 6'd62, 3'd0, 6'd0,  3'd0, 6'd0,  3'd0, 4'd3, 4'd1, 4'd1, 1'b1},
    '{1'b1, 6'd0,  3'd0, 6'd8,  3'd0, 6'd0,  3'd0, 4'd2, 4'd9, 4'd2, 1'b1},
    '{1'b0, 6'd0,  3'd0, 6'd0,  3'd0, 6'd16, 3'd0, 4'd9, 4'd1, 4'd1, 1'b1}
  };

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         host_we = 1'b0;
  logic [2:0]   host_waddr = '0, host_raddr = '0;
  logic [511:0] host_wdata = '0, host_rdata;
  logic         cmd_valid = 1'b0, cmd_ready, cmd_op = 1'b0;
  logic [5:0]   cmd_a_row = '0, cmd_b_row = '0, cmd_d_row = '0;
  logic [2:0]   cmd_a_col = '0, cmd_b_col = '0, cmd_d_col = '0;
  logic [3:0]   cmd_m = '0, cmd_k = '0, cmd_n = '0;
  logic         done, err;

  int checks = 0, fails = 0;
  logic [511:0] mdl [NREGS];

  always #2 clk = ~clk;

  blkrf_engine #(.NREGS(NREGS)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_a_row(cmd_a_row), .cmd_a_col(cmd_a_col), .cmd_b_row(cmd_b_row),
    .cmd_b_col(cmd_b_col), .cmd_d_row(cmd_d_row), .cmd_d_col(cmd_d_col),
    .cmd_m(cmd_m), .cmd_k(cmd_k), .cmd_n(cmd_n), .done(done), .err(err)
  );

  task automatic check(input bit ok, input string tag, input logic [511:0] act,
                       input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mix(input int s, input int r, input int w);
    logic [31:0] x;
    x = 32'(s * 7919 + r * 131 + w * 17 + 1);
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x * 32'h9E3779B1;
  endfunction

  function automatic logic [7:0] mget(input int g, input int c);
    return mdl[g / 8][((g % 8) * 8 + c) * 8 +: 8];
  endfunction

  task automatic mset(input int g, input int c, input logic [7:0] v);
    mdl[g / 8][((g % 8) * 8 + c) * 8 +: 8] = v;
  endtask

  task automatic host_write(input int r, input logic [511:0] d);
    @(negedge clk);
    host_we = 1'b1; host_waddr = 3'(r); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic preload(input int seed);
    for (int r = 0; r < NREGS; r++) begin
      for (int w = 0; w < 16; w++) mdl[r][w * 32 +: 32] = mix(seed, r, w);
      host_write(r, mdl[r]);
    end
  endtask

  task automatic model_apply(input vec_t v);
    logic [7:0] snap [64];
    if (v.op == 1'b0) begin
      for (int i = 0; i < int'(v.m); i++)
        for (int j = 0; j < int'(v.n); j++)
          snap[i * 8 + j] = mget(int'(v.ar) + i, int'(v.ac) + j);
      for (int i = 0; i < int'(v.m); i++)
        for (int j = 0; j < int'(v.n); j++)
          mset(int'(v.dr) + i, int'(v.dc) + j, snap[i * 8 + j]);
    end else begin
      logic [511:0] src [NREGS];
      for (int r = 0; r < NREGS; r++) src[r] = mdl[r];
      for (int i = 0; i < int'(v.m); i++)
        for (int j = 0; j < int'(v.n); j++) begin
          int acc, w;
          acc = 0;
          for (int t = 0; t < int'(v.k); t++) begin
            int ga, gb;
            ga = int'(v.ar) + i; gb = int'(v.br) + t;
            acc += int'($signed(src[ga / 8][((ga % 8) * 8 + int'(v.ac) + t) * 8 +: 8])) *
                   int'($signed(src[gb / 8][((gb % 8) * 8 + int'(v.bc) + j) * 8 +: 8]));
          end
          w = i * int'(v.n) + j;
          mdl[int'(v.dr) / 8 + w / 16][(w % 16) * 32 +: 32] = 32'(acc);
        end
    end
  endtask

  task automatic drive_cmd(input vec_t v);
    cmd_op = v.op; cmd_a_row = v.ar; cmd_a_col = v.ac; cmd_b_row = v.br;
    cmd_b_col = v.bc; cmd_d_row = v.dr; cmd_d_col = v.dc;
    cmd_m = v.m; cmd_k = v.k; cmd_n = v.n; cmd_valid = 1'b1;
  endtask

  task automatic run_cmd(input vec_t v, output int lat, output logic e);
    @(negedge clk);
    drive_cmd(v);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 0;
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    e = err;
  endtask

  task automatic compare_all(input string tag);
    for (int r = 0; r < NREGS; r++) begin
      @(negedge clk);
      host_raddr = 3'(r);
      #1;
      check(host_rdata === mdl[r], tag, host_rdata, mdl[r]);
    end
  endtask

  initial begin : watchdog
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int   lat, explat;
    logic e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state: R1 R6 R7
    check(cmd_ready === 1'b1, "R6 ready after reset", 512'(cmd_ready), 512'(1));
    check(done === 1'b0 && err === 1'b0, "R7 no done after reset", 512'({done, err}), 512'(0));
    for (int r = 0; r < NREGS; r++) mdl[r] = '0;
    compare_all("R1 registers clear at reset");

    // R1: flat write / read
    mdl[3] = {16{32'hA5C3_0F1E}};
    host_write(3, mdl[3]);
    compare_all("R1 flat vector write");

    // R2: element (5,6) of register 1 lands at bits 46*8
    for (int b = 0; b < 64; b++) mdl[1][b * 8 +: 8] = 8'(b);
    host_write(1, mdl[1]);
    run_cmd('{1'b0, 6'd13, 3'd6, 6'd0, 3'd0, 6'd0, 3'd0, 4'd1, 4'd1, 4'd1, 1'b0}, lat, e);
    @(negedge clk); host_raddr = 3'd0; #1;
    check(host_rdata[7:0] === 8'd46, "R2 element position", 512'(host_rdata[7:0]), 512'(46));

    // table-driven vectors: R3 R4 R5 R8 R10
    for (int vi = 0; vi < NVEC; vi++) begin
      vec_t v;
      v = VECS[vi];
      preload(vi + 10);
      run_cmd(v, lat, e);
      explat = v.bad ? 0 : (v.op ? int'(v.m) * int'(v.n) : 2 * int'(v.m) * int'(v.n));
      check(e === v.bad, v.bad ? "R8 err flag" : "R7 err low", 512'(e), 512'(v.bad));
      check(lat == explat, "R10 latency", 512'(lat), 512'(explat));
      if (!v.bad) model_apply(v);
      compare_all(v.bad ? "R8 no change on refusal" : (v.op ? "R5 matmul result" : "R3/R4 move result"));
    end

    // R9 R6 R7: host write during busy is dropped, ready low, done is a pulse
    preload(99);
    @(negedge clk);
    drive_cmd(VECS[6]);
    @(negedge clk);
    cmd_valid = 1'b0;
    host_we = 1'b1; host_waddr = 3'd3; host_wdata = {16{32'hDEAD_BEEF}};
    check(cmd_ready === 1'b0, "R6 busy after accept", 512'(cmd_ready), 512'(0));
    @(negedge clk);
    host_we = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    check(done === 1'b0, "R7 done single cycle", 512'(done), 512'(0));
    model_apply(VECS[6]);
    compare_all("R9 busy host write ignored");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule